// File: doc/BRIEF.md
# Used-Bit Clock Replacement Selector

This unit picks which way of an N-way set-associative cache gets evicted on a miss. It holds one used flag per cache line and one rotating pointer per set. Every access to a line, whether a hit or the fill after a miss, marks that line as used. When the cache controller asks for a victim in a set, the unit returns an invalid way if the set has one. Otherwise it walks the pointer around the set one way per clock. It clears each used flag it passes and stops at the first way whose flag is already clear. The result is a cheap approximation of least-recently-used order. Tag and data storage live elsewhere; the controller supplies the set's valid bits with each request.

An optional mode, selected by an input pin, handles an access that would leave every other way of its set marked used. In that case the other flags are dropped and only the accessed line stays marked, so the next scan ends sooner. With a single way the unit degenerates to a fixed answer of way 0.

Top module: `clock_repl_sel`

## Requirements
- R1: After reset every used flag and every set pointer is 0, and `vic_done` and `vic_busy` are low. A first victim request on a fully valid set with no prior access returns way 0, with `vic_done` high after the second rising edge counted from the edge that samples the request.
- R2: An access (`acc_en` high at a rising edge) sets the used flag of line (`acc_set`, `acc_way`) to 1, whether the access is a hit or a fill.
- R3: If any bit of `vic_valid` is 0 when a request is sampled, the result is the lowest-numbered way whose bit is 0. `vic_done` rises at that same edge, one edge after the request.
- R4: If all ways are valid, the scan starts at the set's pointer and examines one way per clock. It picks the first way whose used flag is 0. `vic_done` is high after 2 + k edges, counted from and including the sampling edge, where k is the number of used flags passed.
- R5: Each used flag found at 1 during a scan is cleared to 0 as the pointer passes it.
- R6: With `fold_en` high, an access that would leave all other ways of the set used clears those others; only the accessed way keeps its flag at 1.
- R7: With one way, every request returns way 0 with `vic_done` high one edge after the request, regardless of prior accesses.
- R8: A scan never examines more than WAYS+1 ways, because a full lap clears every flag.
- R9: After a victim is chosen by either path, the set's pointer rests on the way after the victim, wrapping from WAYS-1 to 0.
- R10: When an access falls on the set under scan in the same cycle, the scan sees the access's update first. An accessed way at the pointer is therefore passed (and cleared), not chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe (hit or fill) |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way touched by the access |
| fold_en | input | 1 | Enables clearing the other flags when a set would become fully used |
| vic_req | input | 1 | Victim request, accepted when not busy |
| vic_set | input | SET_W | Set index of the victim request |
| vic_valid | input | WAYS | Valid bit per way of the requested set |
| vic_done | output | 1 | One-cycle flag: vic_way holds the chosen victim |
| vic_way | output | WAY_W | Chosen victim way |
| vic_busy | output | 1 | High while a scan is in progress |

## Verification
A used flag left wrongly set or cleared does not appear at the ports until the next victim request on that set. It then shows as a different victim way, and as a scan latency that is off by one cycle for each flag in error. A pointer stored in the wrong place shows the same way on the following request to that set. The bench therefore follows each sequence of accesses with requests that compare both the chosen way and the exact cycle of `vic_done` against a model of flags and pointers.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/crs_used_bits.sv
module crs_used_bits #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fold_en,
  input  logic [SET_W-1:0] scan_set,
  input  logic             clr_en,
  input  logic [WAY_W-1:0] clr_way,
  output logic [WAYS-1:0]  look_bits
);
  localparam logic [WAYS-1:0] ALL_ONES = {WAYS{1'b1}};

  logic [WAYS-1:0] used_q [SETS];
  logic [WAYS-1:0] upd    [SETS];
  logic [WAYS-1:0] nxt    [SETS];
  logic [WAYS-1:0] acc_hot;
  logic [WAYS-1:0] clr_hot;

  assign acc_hot = WAYS'(1) << acc_way;
  assign clr_hot = WAYS'(1) << clr_way;

  // access update first, scan clear afterwards
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      upd[s] = used_q[s];
      if (acc_en && acc_set == SET_W'(s)) begin
        if (fold_en && ((used_q[s] | acc_hot) == ALL_ONES))
          upd[s] = acc_hot;
        else
          upd[s] = used_q[s] | acc_hot;
      end
      nxt[s] = upd[s];
      if (clr_en && scan_set == SET_W'(s))
        nxt[s] = upd[s] & ~clr_hot;
    end
  end

  assign look_bits = upd[scan_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) used_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) used_q[s] <= nxt[s];
    end
  end

  // bookkeeping for the checks below
  logic             acc_d;
  logic [SET_W-1:0] set_d;
  logic [WAY_W-1:0] way_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_d <= 1'b0;
      set_d <= '0;
      way_d <= '0;
    end else begin
      acc_d <= acc_en && !(clr_en && scan_set == acc_set && clr_way == acc_way);
      set_d <= acc_set;
      way_d <= acc_way;
    end
  end

  AST_ACCESS_MARKS: assert property (@(posedge clk) disable iff (rst)
    acc_d |-> used_q[set_d][way_d]); // R2

  AST_CLEAR_ONLY_USED: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> look_bits[clr_way]); // R5

  for (genvar g = 0; g < SETS; g++) begin : g_rst_chk
    AST_RESET_ZERO: assert property (@(posedge clk)
      $past(rst) |-> (used_q[g] == '0)); // R1
  end
endmodule

// File: rtl/crs_ptr_table.sv
module crs_ptr_table #(
  parameter int SETS  = 16,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_ptr,
  input  logic             we,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_ptr
);
  logic [WAY_W-1:0] ptr_q [SETS];

  assign rd_ptr = ptr_q[rd_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (we) begin
      ptr_q[wr_set] <= wr_ptr;
    end
  end

  AST_PTR_RESET: assert property (@(posedge clk)
    $past(rst) |-> (ptr_q[0] == '0)); // R1
endmodule

// File: rtl/crs_victim_fsm.sv
module crs_victim_fsm
  import crs_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SET_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAYS-1:0]  req_mask,
  input  logic [WAYS-1:0]  look_bits,
  input  logic [WAY_W-1:0] ptr_rd,
  output logic [SET_W-1:0] rd_set,
  output logic [SET_W-1:0] scan_set,
  output logic             clr_en,
  output logic [WAY_W-1:0] clr_way,
  output logic             ptr_we,
  output logic [SET_W-1:0] ptr_wset,
  output logic [WAY_W-1:0] ptr_wdata,
  output logic             done,
  output logic [WAY_W-1:0] victim,
  output logic             busy
);
  localparam int CNT_W = $clog2(WAYS + 1) + 1;

  scan_st_e         st_q;
  logic [SET_W-1:0] set_q;
  logic [WAYS-1:0]  mask_q;
  logic [WAY_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [WAY_W-1:0] victim_q;

  logic             any_inv;
  logic [WAY_W-1:0] first_inv;
  logic             take;
  logic             hit_free;

  function automatic logic [WAY_W-1:0] step(input logic [WAY_W-1:0] w);
    return (w == WAY_W'(WAYS - 1)) ? '0 : w + WAY_W'(1);
  endfunction

  always_comb begin
    first_inv = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!req_mask[i]) first_inv = WAY_W'(i);
  end

  assign any_inv  = ~&req_mask;
  assign take     = req && (st_q == ST_IDLE);
  assign hit_free = (st_q == ST_SCAN) && !look_bits[cur_q];

  assign rd_set   = (st_q == ST_IDLE) ? req_set : set_q;
  assign scan_set = set_q;
  assign clr_en   = (st_q == ST_SCAN) && look_bits[cur_q];
  assign clr_way  = cur_q;

  always_comb begin
    ptr_we    = 1'b0;
    ptr_wset  = set_q;
    ptr_wdata = step(cur_q);
    if (take && any_inv) begin
      ptr_we    = 1'b1;
      ptr_wset  = req_set;
      ptr_wdata = step(first_inv);
    end else if (hit_free) begin
      ptr_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      set_q    <= '0;
      mask_q   <= '0;
      cur_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            set_q  <= req_set;
            mask_q <= req_mask;
            cnt_q  <= '0;
            if (any_inv) begin
              victim_q <= first_inv;
              done_q   <= 1'b1;
            end else begin
              cur_q <= ptr_rd;
              st_q  <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (hit_free) begin
            victim_q <= cur_q;
            done_q   <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            cur_q <= step(cur_q);
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign victim = victim_q;
  assign busy   = (st_q == ST_SCAN);

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SCAN) |-> (cnt_q <= CNT_W'(WAYS))); // R8

  AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(&mask_q)) |-> !mask_q[victim_q]); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy); // R4
endmodule

// File: rtl/clock_repl_sel.sv
module clock_repl_sel #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fold_en,
  input  logic             vic_req,
  input  logic [SET_W-1:0] vic_set,
  input  logic [WAYS-1:0]  vic_valid,
  output logic             vic_done,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_busy
);
  if (WAYS == 1) begin : g_direct
    logic done_q;
    always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= vic_req;
    end
    assign vic_done = done_q;
    assign vic_way  = '0;
    assign vic_busy = 1'b0;

    AST_DM_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
      vic_req |=> vic_done); // R7
  end else begin : g_assoc
    logic [WAYS-1:0]  look_bits;
    logic [SET_W-1:0] rd_set, scan_set, ptr_wset;
    logic [WAY_W-1:0] ptr_rd, clr_way, ptr_wdata;
    logic             clr_en, ptr_we;

    crs_used_bits #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_used (
      .clk(clk), .rst(rst),
      .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way), .fold_en(fold_en),
      .scan_set(scan_set), .clr_en(clr_en), .clr_way(clr_way),
      .look_bits(look_bits)
    );

    crs_ptr_table #(.SETS(SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_ptr (
      .clk(clk), .rst(rst),
      .rd_set(rd_set), .rd_ptr(ptr_rd),
      .we(ptr_we), .wr_set(ptr_wset), .wr_ptr(ptr_wdata)
    );

    crs_victim_fsm #(.WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_fsm (
      .clk(clk), .rst(rst),
      .req(vic_req), .req_set(vic_set), .req_mask(vic_valid),
      .look_bits(look_bits), .ptr_rd(ptr_rd),
      .rd_set(rd_set), .scan_set(scan_set),
      .clr_en(clr_en), .clr_way(clr_way),
      .ptr_we(ptr_we), .ptr_wset(ptr_wset), .ptr_wdata(ptr_wdata),
      .done(vic_done), .victim(vic_way), .busy(vic_busy)
    );

    AST_PTR_AFTER_VICTIM: assert property (@(posedge clk) disable iff (rst)
      (ptr_we && !vic_busy && vic_req) |-> (ptr_wset == vic_set)); // R9
  end
endmodule

// File: tb/tb_clock_repl_sel.sv
`timescale 1ns/1ps
module tb_clock_repl_sel;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int SW = 4;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          acc_en = 0, fold_en = 0, vic_req = 0;
  logic [SW-1:0] acc_set = 0, vic_set = 0;
  logic [WW-1:0] acc_way = 0;
  logic [WAYS-1:0] vic_valid = '1;
  logic          vic_done, vic_busy;
  logic [WW-1:0] vic_way;

  logic dm_req = 0;
  logic dm_done, dm_busy;
  logic [0:0] dm_way;

  clock_repl_sel #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way),
    .fold_en(fold_en), .vic_req(vic_req), .vic_set(vic_set), .vic_valid(vic_valid),
    .vic_done(vic_done), .vic_way(vic_way), .vic_busy(vic_busy));

  clock_repl_sel #(.WAYS(1), .SETS(SETS)) dut_dm (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_set(acc_set), .acc_way(1'b0),
    .fold_en(fold_en), .vic_req(dm_req), .vic_set(vic_set), .vic_valid(1'b1),
    .vic_done(dm_done), .vic_way(dm_way), .vic_busy(dm_busy));

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [WAYS-1:0] m_used [SETS];
  int m_ptr [SETS];
  int q_way [$];
  string q_tag [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int w);
    return (w == WAYS - 1) ? 0 : w + 1;
  endfunction

  task automatic model_touch(input int s, input int w);
    logic [WAYS-1:0] h;
    h = WAYS'(1) << w;
    if (fold_en && ((m_used[s] | h) == '1)) m_used[s] = h;
    else m_used[s] = m_used[s] | h;
  endtask

  task automatic do_access(input int s, input int w);
    acc_en = 1; acc_set = SW'(s); acc_way = WW'(w);
    @(negedge clk);
    acc_en = 0;
    model_touch(s, w);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && vic_done) begin
      if (q_way.size() == 0) chk(0, "R4 unexpected done", int'(vic_way), -1);
      else begin
        int ew;
        string t;
        ew = q_way.pop_front();
        t = q_tag.pop_front();
        chk(int'(vic_way) == ew, t, int'(vic_way), ew);
      end
    end
  end

  task automatic do_victim(input int s, input logic [WAYS-1:0] mask, input bit side,
                           input int sw, input string tag, output int got_way);
    int ew, ec, c, cl, n;
    if (mask != '1) begin
      ew = 0;
      for (int i = WAYS - 1; i >= 0; i--) if (!mask[i]) ew = i;
      ec = 1;
      m_ptr[s] = nxt(ew);
    end else begin
      c = m_ptr[s];
      cl = 0;
      if (side) model_touch(s, sw);
      for (int k = 0; k <= WAYS; k++) begin
        if (!m_used[s][c]) break;
        m_used[s][c] = 1'b0;
        c = nxt(c);
        cl++;
      end
      ew = c;
      ec = 2 + cl;
      m_ptr[s] = nxt(c);
    end
    q_way.push_back(ew);
    q_tag.push_back({tag, " way"});
    vic_req = 1; vic_set = SW'(s); vic_valid = mask;
    @(negedge clk);
    vic_req = 0;
    n = 1;
    if (side) begin
      acc_en = 1; acc_set = SW'(s); acc_way = WW'(sw);
    end
    while (!vic_done && n < 40) begin
      @(negedge clk);
      acc_en = 0;
      n++;
    end
    acc_en = 0;
    chk(n == ec, {tag, " latency"}, n, ec);
    got_way = ew;
    @(negedge clk);
  endtask

  initial begin
    int w;
    for (int s = 0; s < SETS; s++) begin m_used[s] = '0; m_ptr[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(vic_done == 0, "R1 done low", int'(vic_done), 0);
    chk(vic_busy == 0, "R1 busy low", int'(vic_busy), 0);

    // R1: fresh set, all valid -> way 0 in 2 edges
    do_victim(0, '1, 0, 0, "R1 fresh", w);
    chk(w == 0, "R1 literal way", w, 0);

    // R2 R4 R5 R9: mark ways 0,1 of set 3
    do_access(3, 0);
    do_access(3, 1);
    do_victim(3, '1, 0, 0, "R4 scan past two", w);
    chk(w == 2, "R5 literal way", w, 2);
    do_victim(3, '1, 0, 0, "R9 pointer after victim", w);
    chk(w == 3, "R9 literal way", w, 3);
    do_victim(3, '1, 0, 0, "R5 cleared flag reused", w);
    chk(w == 0, "R5 literal way", w, 0);

    // R3: invalid preference
    do_access(4, 2);
    do_victim(4, 4'b1011, 0, 0, "R3 single invalid", w);
    do_victim(4, 4'b0000, 0, 0, "R3 all invalid", w);
    do_victim(4, 4'b0101, 0, 0, "R3 lowest invalid", w);
    chk(w == 1, "R3 literal way", w, 1);
    do_victim(4, '1, 0, 0, "R9 ptr after invalid pick", w);

    // R8: full lap
    for (int i = 0; i < WAYS; i++) do_access(7, i);
    do_victim(7, '1, 0, 0, "R8 full lap", w);

    // R6: fold mode
    fold_en = 1;
    for (int i = 0; i < WAYS; i++) do_access(9, i);
    do_victim(9, '1, 0, 0, "R6 fold keeps one", w);
    do_victim(9, '1, 0, 0, "R6 fold next", w);
    do_victim(9, '1, 0, 0, "R6 fold accessed way kept", w);
    fold_en = 0;

    // R10: access at the pointer during the first scan cycle
    do_victim(5, '1, 1, 0, "R10 same cycle access", w);
    chk(w == 1, "R10 literal way", w, 1);
    do_victim(5, '1, 0, 0, "R10 follow up", w);

    // R2: independent sets, hit then re-request
    do_access(11, 3);
    do_access(12, 0);
    do_victim(11, '1, 0, 0, "R2 set 11", w);
    do_victim(12, '1, 0, 0, "R2 set 12", w);

    // R7: one-way instance
    do_access(2, 0);
    dm_req = 1;
    @(negedge clk);
    dm_req = 0;
    chk(dm_done == 1, "R7 done one edge", int'(dm_done), 1);
    chk(dm_way == 0, "R7 way zero", int'(dm_way), 0);
    @(negedge clk);
    chk(dm_done == 0, "R7 done pulse", int'(dm_done), 0);

    repeat (3) @(negedge clk);
    chk(q_way.size() == 0, "R4 scoreboard drained", q_way.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule